// File: doc/BRIEF.md
# Flash Device Identifier Probe

This block finds out which of two supported byte-wide parallel NOR flash parts sits on the boot bus. Straight after reset, and again each time a start pulse arrives while it is idle, it puts the part into identifier mode, waits a programmable settle time, reads a manufacturer byte and a device byte, and then returns the part to array-read mode.

The two bytes are joined into a 16-bit identifier. The bus location of the device byte depends on the manufacturer byte, because the larger part places it at a different offset. The identifier is decoded into a valid or unsupported verdict and a size-select bit. Neighbouring blocks use that bit to choose between the 1 MiB and 4 MiB array sizes. Bus cycles are reduced to single-cycle write and read strobes. Read data is returned by the part one cycle after the read strobe.

Top module: `flash_id_probe`

## Requirements
- R1: After reset is released, a probe starts by itself. `idValid` and `idUnsupported` are never high together, and both are low from the cycle after a probe begins until it completes.
- R2: The first bus operation of a probe is one write-strobe cycle that carries data 0x90 at address 0x8000.
- R3: The first read strobe comes exactly DELAY_CYCLES + 1 cycles after the identifier command cycle, so at least DELAY_CYCLES idle cycles separate them.
- R4: The first identifier byte is read at address 0.
- R5: The second identifier byte is read at address 2 when the first byte is 0xB0, and at address 1 for any other first byte.
- R6: Read data is captured in the cycle after its read strobe. `devId` holds the first byte in bits 15:8 and the second byte in bits 7:0.
- R7: After the second read, a single write-strobe cycle carries 0xFF to address 0x8000. The result flags rise in the cycle after that write.
- R8: An identifier of 0x89A6 gives idValid=1 and sizeIs4M=0. An identifier of 0xB0D4 gives idValid=1 and sizeIs4M=1.
- R9: Any other identifier gives idUnsupported=1, idValid=0 and sizeIs4M=0.
- R10: A start pulse while idle runs a new probe. A start pulse while a probe is running is ignored: it adds no identifier command and no second result.
- R11: The write and read strobes are never high in the same cycle, and the results stay stable while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Request to run a new probe |
| flashAddr | output | ADDR_W | Flash byte address |
| flashWrData | output | 8 | Command byte to the flash |
| flashWrEn | output | 1 | Single-cycle write strobe |
| flashRdEn | output | 1 | Single-cycle read strobe |
| flashRdData | input | 8 | Byte returned by the flash the cycle after a read strobe |
| devId | output | 16 | Identifier found by the last completed probe |
| idValid | output | 1 | The identifier is one of the supported parts |
| idUnsupported | output | 1 | The identifier is not supported |
| sizeIs4M | output | 1 | The supported part is the 4 MiB device |

## Verification
A behavioural flash model answers identifier reads from a small table and array reads from an address-derived pattern. The probe is run with the 1 MiB identifier and with the 4 MiB identifier. A decoy byte sits at offset 1 when the first byte is 0xB0, so a wrong second-byte offset shows up as a wrong identifier.

Two unsupported identifiers are also used. One has a 0xB0 first byte and a bad second byte, and one has the small part's first byte with the large part's second byte; together they show that both bytes are compared. A fully unrelated identifier is tested as well. A start pulse issued during the settle wait separates a design that ignores it from one that restarts or queues a second probe.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

  localparam logic [7:0]  CMD_READ_ID    = 8'h90;
  localparam logic [7:0]  CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0]  WIDE_PART_HI   = 8'hB0;
  localparam logic [15:0] ID_SMALL_PART  = 16'h89A6;
  localparam logic [15:0] ID_LARGE_PART  = 16'hB0D4;
  localparam int          CMD_OFFSET     = 32'h8000;

  typedef enum logic [1:0] {
    ADDR_CMD,
    ADDR_FIRST,
    ADDR_SECOND
  } addrSel_e;

  typedef struct packed {
    logic     busWr;
    logic     busRd;
    addrSel_e addrSel;
    logic     exitCmd;
    logic     capFirst;
    logic     capSecond;
    logic     clrResult;
    logic     publish;
  } probeStrobe_t;

  typedef enum logic [3:0] {
    ST_LAUNCH,
    ST_IDLE,
    ST_ENTER,
    ST_SETTLE,
    ST_RD_FIRST,
    ST_CAP_FIRST,
    ST_RD_SECOND,
    ST_CAP_SECOND,
    ST_EXIT
  } probeState_e;

endpackage

// File: rtl/flash_probe_ctrl.sv
module flash_probe_ctrl
  import flash_probe_pkg::*;
#(
  parameter int DELAY_CYCLES = 750
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startPulse,
  output probeStrobe_t strobe
);

  localparam int CNT_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(DELAY_CYCLES - 1);

  probeState_e state, stateNext;
  logic [CNT_W-1:0] waitCnt;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_LAUNCH: begin
        strobe.clrResult = 1'b1;
        stateNext        = ST_ENTER;
      end
      ST_IDLE: begin
        if (startPulse) begin
          strobe.clrResult = 1'b1;
          stateNext        = ST_ENTER;
        end
      end
      ST_ENTER: begin
        strobe.busWr   = 1'b1;
        strobe.addrSel = ADDR_CMD;
        stateNext      = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (waitCnt == LAST_WAIT) stateNext = ST_RD_FIRST;
      end
      ST_RD_FIRST: begin
        strobe.busRd   = 1'b1;
        strobe.addrSel = ADDR_FIRST;
        stateNext      = ST_CAP_FIRST;
      end
      ST_CAP_FIRST: begin
        strobe.capFirst = 1'b1;
        stateNext       = ST_RD_SECOND;
      end
      ST_RD_SECOND: begin
        strobe.busRd   = 1'b1;
        strobe.addrSel = ADDR_SECOND;
        stateNext      = ST_CAP_SECOND;
      end
      ST_CAP_SECOND: begin
        strobe.capSecond = 1'b1;
        stateNext        = ST_EXIT;
      end
      ST_EXIT: begin
        strobe.busWr   = 1'b1;
        strobe.addrSel = ADDR_CMD;
        strobe.exitCmd = 1'b1;
        strobe.publish = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_LAUNCH;
      waitCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_SETTLE) waitCnt <= waitCnt + 1'b1;
      else                    waitCnt <= '0;
    end
  end

endmodule

// File: rtl/flash_probe_datapath.sv
module flash_probe_datapath
  import flash_probe_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  probeStrobe_t      strobe,
  input  logic [7:0]        flashRdData,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [7:0]        flashWrData,
  output logic              flashWrEn,
  output logic              flashRdEn,
  output logic [15:0]       devId,
  output logic              idValid,
  output logic              idUnsupported,
  output logic              sizeIs4M
);

  localparam logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'(CMD_OFFSET);
  localparam logic [ADDR_W-1:0] NEAR_ADDR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] FAR_ADDR  = ADDR_W'(2);
  localparam int NUM_PARTS = 2;

  logic [7:0]  firstByte, secondByte;
  logic [15:0] assembledId;
  logic [NUM_PARTS-1:0] partHit;

  assign assembledId = {firstByte, secondByte};

  genvar g;
  generate
    for (g = 0; g < NUM_PARTS; g++) begin : g_part
      localparam logic [15:0] PART_ID = (g == 0) ? ID_SMALL_PART : ID_LARGE_PART;
      assign partHit[g] = (assembledId == PART_ID);
    end
  endgenerate

  always_comb begin
    case (strobe.addrSel)
      ADDR_CMD:    flashAddr = CMD_ADDR;
      ADDR_SECOND: flashAddr = (firstByte == WIDE_PART_HI) ? FAR_ADDR : NEAR_ADDR;
      default:     flashAddr = '0;
    endcase
  end

  assign flashWrData = strobe.exitCmd ? CMD_READ_ARRAY : CMD_READ_ID;
  assign flashWrEn   = strobe.busWr;
  assign flashRdEn   = strobe.busRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstByte     <= '0;
      secondByte    <= '0;
      devId         <= '0;
      idValid       <= 1'b0;
      idUnsupported <= 1'b0;
      sizeIs4M      <= 1'b0;
    end else begin
      if (strobe.capFirst)  firstByte  <= flashRdData;
      if (strobe.capSecond) secondByte <= flashRdData;
      if (strobe.clrResult) begin
        devId         <= '0;
        idValid       <= 1'b0;
        idUnsupported <= 1'b0;
        sizeIs4M      <= 1'b0;
      end else if (strobe.publish) begin
        devId         <= assembledId;
        idValid       <= |partHit;
        idUnsupported <= ~|partHit;
        sizeIs4M      <= partHit[1];
      end
    end
  end

endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
  import flash_probe_pkg::*;
#(
  parameter int ADDR_W       = 22,
  parameter int DELAY_CYCLES = 750
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [7:0]        flashWrData,
  output logic              flashWrEn,
  output logic              flashRdEn,
  input  logic [7:0]        flashRdData,
  output logic [15:0]       devId,
  output logic              idValid,
  output logic              idUnsupported,
  output logic              sizeIs4M
);

  probeStrobe_t strobe;

  flash_probe_ctrl #(
    .DELAY_CYCLES(DELAY_CYCLES)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .strobe    (strobe)
  );

  flash_probe_datapath #(
    .ADDR_W(ADDR_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .flashRdData  (flashRdData),
    .flashAddr    (flashAddr),
    .flashWrData  (flashWrData),
    .flashWrEn    (flashWrEn),
    .flashRdEn    (flashRdEn),
    .devId        (devId),
    .idValid      (idValid),
    .idUnsupported(idUnsupported),
    .sizeIs4M     (sizeIs4M)
  );

endmodule

// File: rtl/flash_id_probe_chk.sv
module flash_id_probe_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] flashAddr,
  input logic [7:0]        flashWrData,
  input logic              flashWrEn,
  input logic              flashRdEn,
  input logic [15:0]       devId,
  input logic              idValid,
  input logic              idUnsupported,
  input logic              sizeIs4M
);

  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(idValid && idUnsupported));

  a_r1_flags_low_on_read: assert property (@(posedge clk) disable iff (!rstN)
    flashRdEn |-> (!idValid && !idUnsupported));

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(flashWrEn && flashRdEn));

  a_r2_cmd_write: assert property (@(posedge clk) disable iff (!rstN)
    flashWrEn |-> (flashAddr == ADDR_W'(32'h8000)) &&
                  (flashWrData == 8'h90 || flashWrData == 8'hFF));

  a_r7_exit_before_valid: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idValid) |-> ($past(flashWrEn) && $past(flashWrData) == 8'hFF));

  a_r8_large_part: assert property (@(posedge clk) disable iff (!rstN)
    sizeIs4M |-> (idValid && devId == 16'hB0D4));

  a_r9_unsupported_id: assert property (@(posedge clk) disable iff (!rstN)
    idUnsupported |-> (devId != 16'h89A6 && devId != 16'hB0D4 && !sizeIs4M));

endmodule

bind flash_id_probe flash_id_probe_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .flashAddr    (flashAddr),
  .flashWrData  (flashWrData),
  .flashWrEn    (flashWrEn),
  .flashRdEn    (flashRdEn),
  .devId        (devId),
  .idValid      (idValid),
  .idUnsupported(idUnsupported),
  .sizeIs4M     (sizeIs4M)
);

// File: tb/flash_id_probe_tb_top.sv
module flash_id_probe_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 22;
  localparam int DELAY      = 6;

  typedef struct {
    logic [15:0] id;
    logic        valid;
    logic        unsup;
    logic        size4;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startPulse = 1'b0;
  logic [ADDR_W-1:0] flashAddr;
  logic [7:0]        flashWrData;
  logic              flashWrEn;
  logic              flashRdEn;
  logic [7:0]        flashRdData = 8'h00;
  logic [15:0]       devId;
  logic              idValid, idUnsupported, sizeIs4M;

  int nCompared = 0;
  int nMismatch = 0;
  int doneCount = 0;
  bit finished = 1'b0;

  expItem_t expQ[$];

  // flash model state
  logic [7:0] idMem [0:3];
  logic       idMode = 1'b0;
  int         idCmdCount = 0;
  int         exitCount = 0;
  int         gapCnt = 0;
  int         firstGap = 0;
  int         readIdx = 0;
  logic [ADDR_W-1:0] readAddr [0:1];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_id_probe #(.ADDR_W(ADDR_W), .DELAY_CYCLES(DELAY)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .flashAddr(flashAddr), .flashWrData(flashWrData),
    .flashWrEn(flashWrEn), .flashRdEn(flashRdEn), .flashRdData(flashRdData),
    .devId(devId), .idValid(idValid), .idUnsupported(idUnsupported),
    .sizeIs4M(sizeIs4M)
  );

  always @(posedge clk) begin
    gapCnt <= gapCnt + 1;
    if (flashWrEn && flashAddr == ADDR_W'(32'h8000)) begin
      if (flashWrData == 8'h90) begin
        idMode     <= 1'b1;
        idCmdCount <= idCmdCount + 1;
        gapCnt     <= 0;
        readIdx    <= 0;
      end else if (flashWrData == 8'hFF) begin
        idMode    <= 1'b0;
        exitCount <= exitCount + 1;
      end
    end
    if (flashRdEn) begin
      if (idMode)
        flashRdData <= (flashAddr < ADDR_W'(4)) ? idMem[flashAddr[1:0]] : 8'h00;
      else
        flashRdData <= flashAddr[7:0] ^ 8'h5A;
      if (readIdx < 2) readAddr[readIdx] <= flashAddr;
      if (readIdx == 0) firstGap <= gapCnt;
      readIdx <= readIdx + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nCompared++;
    if (!ok) begin
      nMismatch++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare each published result against the scoreboard
  logic prevDone = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (flashRdEn)
        check(!idValid && !idUnsupported, "R1", "flags while reading",
              {30'd0, idValid, idUnsupported}, 32'd0);
      if ((idValid || idUnsupported) && !prevDone) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R10", "unexpected result", {16'd0, devId}, 32'd0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(devId == e.id, "R6", "devId", {16'd0, devId}, {16'd0, e.id});
          check(idValid == e.valid && sizeIs4M == e.size4, "R8", "valid/size",
                {30'd0, idValid, sizeIs4M}, {30'd0, e.valid, e.size4});
          check(idUnsupported == e.unsup, "R9", "unsupported",
                {31'd0, idUnsupported}, {31'd0, e.unsup});
        end
        doneCount++;
      end
      prevDone <= idValid || idUnsupported;
    end
  end

  task automatic loadId(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    idMem[0] = b0; idMem[1] = b1; idMem[2] = b2; idMem[3] = 8'hEE;
  endtask

  task automatic pushExp(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    expItem_t e;
    e.id    = {b0, (b0 == 8'hB0) ? b2 : b1};
    e.valid = (e.id == 16'h89A6) || (e.id == 16'hB0D4);
    e.unsup = !e.valid;
    e.size4 = (e.id == 16'hB0D4);
    expQ.push_back(e);
  endtask

  task automatic waitDone(input int target);
    while (doneCount < target) @(negedge clk);
  endtask

  task automatic postChecks(input logic [7:0] b0, input int cmdBase, input int exitBase);
    logic [ADDR_W-1:0] secExp;
    secExp = (b0 == 8'hB0) ? ADDR_W'(2) : ADDR_W'(1);
    check(idCmdCount == cmdBase + 1, "R2", "id command count", idCmdCount, cmdBase + 1);
    check(firstGap == DELAY, "R3", "settle gap", firstGap, DELAY);
    check(readAddr[0] == '0, "R4", "first read addr", 32'(readAddr[0]), 32'd0);
    check(readAddr[1] == secExp, "R5", "second read addr", 32'(readAddr[1]), 32'(secExp));
    check(exitCount == exitBase + 1 && !idMode, "R7", "exit write count",
          exitCount, exitBase + 1);
  endtask

  task automatic runProbe(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    int cmdBase, exitBase, target;
    cmdBase = idCmdCount; exitBase = exitCount; target = doneCount + 1;
    loadId(b0, b1, b2);
    pushExp(b0, b1, b2);
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
    waitDone(target);
    postChecks(b0, cmdBase, exitBase);
  endtask

  initial begin
    loadId(8'h89, 8'hA6, 8'h00);
    repeat (3) @(negedge clk);
    check(!flashWrEn && !flashRdEn && !idValid && !idUnsupported && !sizeIs4M,
          "R1", "reset state",
          {27'd0, flashWrEn, flashRdEn, idValid, idUnsupported, sizeIs4M}, 32'd0);
    pushExp(8'h89, 8'hA6, 8'h00);
    rstN = 1'b1;
    waitDone(1);
    postChecks(8'h89, 0, 0);  // R1 automatic probe

    // R8 large part, decoy at offset 1
    runProbe(8'hB0, 8'h11, 8'hD4);
    // R9 wide first byte, wrong second byte
    runProbe(8'hB0, 8'hD4, 8'h22);
    // R9 small first byte with large second byte
    runProbe(8'h89, 8'hD4, 8'hA6);
    // R9 unrelated part
    runProbe(8'h12, 8'h34, 8'h56);

    // R10 start ignored while a probe runs
    begin
      int cmdBase, exitBase;
      cmdBase = idCmdCount; exitBase = exitCount;
      loadId(8'h89, 8'hA6, 8'h77);
      pushExp(8'h89, 8'hA6, 8'h77);
      @(negedge clk) startPulse = 1'b1;
      @(negedge clk) startPulse = 1'b0;
      repeat (3) @(negedge clk);
      startPulse = 1'b1;
      @(negedge clk) startPulse = 1'b0;
      waitDone(6);
      postChecks(8'h89, cmdBase, exitBase);
      repeat (3 * DELAY + 20) @(negedge clk);
      check(idCmdCount == cmdBase + 1, "R10", "extra probe after busy start",
            idCmdCount, cmdBase + 1);
      check(doneCount == 6 && expQ.size() == 0, "R10", "result count", doneCount, 6);
      check(idValid && devId == 16'h89A6, "R11", "idle results stable",
            {15'd0, idValid, devId}, {15'd0, 1'b1, 16'h89A6});
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nCompared++;
      nMismatch++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

endmodule